// File: doc/BRIEF.md
# External Interrupt Request and Vector Unit

This block watches two active-low interrupt request pins and turns them into a single request for a CPU. Each pin is brought into the clock domain by a synchronizer. A trigger-type bit, set separately for each source at run time, then decides how the pin sets the source's request flag. In level mode the flag is set on every cycle the pin is low. In edge mode it is set once, on a high-to-low transition.

The request flags and trigger-type bits sit together in a control register. Per-source enable bits and a master enable sit in an enable register. Both registers are written and read through a simple register port.

When an enabled source has its flag set and the master enable is on, the block raises `irq_valid` and drives that source's fixed vector address. Source 0 wins over source 1. The CPU answers with a one-cycle `ack`, which clears the flag of the source being presented.

Top module: `ext_irq_unit`

## Requirements
- R1: A pin change takes effect on a request flag at the third rising clock edge after the pin changes, because of the two synchronizer stages plus the flag register. At the second edge the flag has not yet changed.
- R2: Level mode is selected by a trigger-type bit of 0. In this mode the source's flag is set on every cycle in which the synchronized pin is low. This holds even in a cycle where the source is acknowledged.
- R3: Edge mode is selected by a trigger-type bit of 1. In this mode the flag is set only when the previous synchronized sample is high and the current one is low. A pin that stays low does not set the flag again after it has been cleared.
- R4: When `ack` is high while `irq_valid` is high, the flag of the presented source is cleared at that clock edge, unless a hardware event sets it in the same cycle.
- R5: Control register (`reg_sel`=0) bit layout: source 0 trigger type is bit 0 and source 0 flag is bit 1; source 1 trigger type is bit 2 and source 1 flag is bit 3; all other bits read 0. Source 0 vectors to 0x0003 and source 1 vectors to 0x0013.
- R6: Enable register (`reg_sel`=1) bit layout: bit 0 enables source 0, bit 2 enables source 1, and bit 7 is the master enable; all other bits read 0. `irq_valid` is high only if some source has its flag set, its own enable set, and the master enable set.
- R7: When both sources are pending and enabled, source 0 is presented first (vector 0x0003).
- R8: A write to the control register stores the trigger-type bits. A flag bit written as 1 raises that request just as a hardware event would. A flag bit written as 0 clears the request, unless a hardware event sets it in the same cycle.
- R9: After reset, all flags, trigger-type bits and enable bits are 0 and `irq_valid` is low. The synchronizer and previous-sample registers start high, so a pin held low through reset does not count as an edge.
- R10: An `ack` while `irq_valid` is low has no effect. Pending flags that are masked survive it and are presented once they are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_pin_n | input | 2 | Active-low request pins, bit i for source i |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ack | input | 1 | One-cycle acknowledge from the CPU |
| irq_valid | output | 1 | A request is being presented |
| irq_vector | output | 16 | Vector address of the presented source |

## Verification
The bench targets the difference between the two trigger modes after an acknowledge. A held-low pin must bring the flag straight back in level mode and must leave it clear in edge mode. A design that mixed the modes up would either lose a level request or keep serving an edge request forever.

The bench counts the exact synchronizer latency, so an extra or missing stage shows up as a flag that appears one cycle late or early. With both sources pending it checks the order of service; swapped priority would return 0x0013 first.

It also acknowledges while the requests are masked, and writes 0 and 1 into the flag bits. A design that cleared on a stray ack, or ignored software writes, would lose or invent requests there.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NSRC   = 2;
  localparam int VEC_W  = 16;
  localparam int REG_W  = 8;
  localparam int SEL_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int MASTER_BIT = 7;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 16;

  function automatic int ctl_trig_bit(int i);
    return 2 * i;
  endfunction

  function automatic int ctl_flag_bit(int i);
    return 2 * i + 1;
  endfunction

  function automatic int en_bit(int i);
    return 2 * i;
  endfunction

  function automatic logic [VEC_W-1:0] vec_addr(int i);
    return VEC_W'(VEC_BASE + VEC_STRIDE * i);
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic lvl
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], pin_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign lvl = chain_q[STAGES-1];
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_lvl,
  input  logic trig_edge,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic ack_clr,
  output logic flag,
  output logic prev_lvl
);
  logic prev_q, prev_d;
  logic flag_q, flag_d;
  logic hw_set;

  // falling edge against the last sample, or a plain low level
  always_comb hw_set = trig_edge ? (prev_q & ~sync_lvl) : ~sync_lvl;

  always_comb begin
    prev_d = sync_lvl;
    flag_d = flag_q;
    if (hw_set)       flag_d = 1'b1;
    else if (sw_wr)   flag_d = sw_val;
    else if (ack_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign flag     = flag_q;
  assign prev_lvl = prev_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import ext_irq_pkg::*;
(
  input  logic [NSRC-1:0]  flag,
  input  logic [NSRC-1:0]  en,
  input  logic             master,
  output logic             valid,
  output logic [SEL_W-1:0] sel,
  output logic [VEC_W-1:0] vector
);
  always_comb begin
    valid = 1'b0;
    sel   = '0;
    // descending scan so the lowest index is the last, winning, match
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (flag[i] && en[i] && master) begin
        valid = 1'b1;
        sel   = SEL_W'(i);
      end
    end
    vector = vec_addr(int'(sel));
  end
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req_pin_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ack,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  logic              rst_q;
  logic              ctrl_wr, en_wr;
  logic [NSRC-1:0]   trig_q, trig_d;
  logic [NSRC-1:0]   en_q, en_d;
  logic              master_q, master_d;
  logic [NSRC-1:0]   sync_s, prev_s, flag, ack_clr;
  logic [SEL_W-1:0]  sel;
  logic              unused_bits;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_q)
  );

  assign ctrl_wr     = reg_wr & ~reg_sel;
  assign en_wr       = reg_wr &  reg_sel;
  assign unused_bits = ^reg_wdata;

  always_comb begin
    trig_d   = trig_q;
    en_d     = en_q;
    master_d = master_q;
    for (int i = 0; i < NSRC; i++) begin
      if (ctrl_wr) trig_d[i] = reg_wdata[ctl_trig_bit(i)];
      if (en_wr)   en_d[i]   = reg_wdata[en_bit(i)];
    end
    if (en_wr) master_d = reg_wdata[MASTER_BIT];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      trig_q   <= '0;
      en_q     <= '0;
      master_q <= 1'b0;
    end else begin
      trig_q   <= trig_d;
      en_q     <= en_d;
      master_q <= master_d;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_q), .pin_n(req_pin_n[g]), .lvl(sync_s[g])
    );
    assign ack_clr[g] = ack & irq_valid & (sel == SEL_W'(g));
    irq_flag_cell u_flag (
      .clk(clk), .rst_n(rst_q), .sync_lvl(sync_s[g]), .trig_edge(trig_q[g]),
      .sw_wr(ctrl_wr), .sw_val(reg_wdata[ctl_flag_bit(g)]),
      .ack_clr(ack_clr[g]), .flag(flag[g]), .prev_lvl(prev_s[g])
    );
  end

  irq_arbiter u_arb (
    .flag(flag), .en(en_q), .master(master_q),
    .valid(irq_valid), .sel(sel), .vector(irq_vector)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (!reg_sel) begin
        reg_rdata[ctl_trig_bit(i)] = trig_q[i];
        reg_rdata[ctl_flag_bit(i)] = flag[i];
      end else begin
        reg_rdata[en_bit(i)] = en_q[i];
      end
    end
    if (reg_sel) reg_rdata[MASTER_BIT] = master_q;
  end
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk
  import ext_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_q,
  input logic [NSRC-1:0]  flag,
  input logic [NSRC-1:0]  trig_q,
  input logic [NSRC-1:0]  sync_s,
  input logic [NSRC-1:0]  prev_s,
  input logic [NSRC-1:0]  en_q,
  input logic             master_q,
  input logic             ctrl_wr,
  input logic             ack,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vector
);
  // R6
  no_master_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !master_q |-> !irq_valid);

  // R5
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_q)
    irq_valid |-> (irq_vector == 16'h0003 || irq_vector == 16'h0013));

  // R7
  prio_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (flag[0] && en_q[0] && master_q) |-> (irq_valid && irq_vector == 16'h0003));

  // R2
  level_set_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!trig_q[1] && !sync_s[1]) |=> flag[1]);

  // R3
  edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (trig_q[0] && !flag[0] && !ctrl_wr && !(prev_s[0] && !sync_s[0])) |=> !flag[0]);

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ack && irq_valid && irq_vector == 16'h0003 && trig_q[0] && !ctrl_wr &&
     !(prev_s[0] && !sync_s[0])) |=> !flag[0]);
endmodule

bind ext_irq_unit ext_irq_chk u_chk (
  .clk(clk), .rst_q(rst_q), .flag(flag), .trig_q(trig_q), .sync_s(sync_s),
  .prev_s(prev_s), .en_q(en_q), .master_q(master_q), .ctrl_wr(ctrl_wr),
  .ack(ack), .irq_valid(irq_valid), .irq_vector(irq_vector)
);

// File: tb/tb_ext_irq_unit.sv
module tb_ext_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_pin_n = 2'b11;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        ack = 1'b0;
  logic        irq_valid;
  logic [15:0] irq_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  localparam logic [15:0] NONE = 16'hFFFF;

  always #5 clk = ~clk;

  ext_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .req_pin_n(req_pin_n), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack(ack), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(logic sel, logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd_check(string req, logic sel, logic [7:0] exp);
    reg_sel = sel;
    #1;
    check(req, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic do_ack(logic [15:0] exp_vec);
    exp_q.push_back(exp_vec);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  // monitor: every ack cycle is compared with the next queued expectation
  always @(negedge clk) begin
    if (ack && rst_n) begin
      logic [15:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : NONE;
      if (e == NONE) check("R10 ack-idle", {15'd0, irq_valid}, 16'd0);
      else           check("R4/R7 ack-vector", irq_valid ? irq_vector : NONE, e);
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R9 reset state
    rd_check("R9 ctrl", 1'b0, 8'h00);
    rd_check("R9 enable", 1'b1, 8'h00);
    check("R9 valid", {15'd0, irq_valid}, 16'd0);

    // level mode on source 0
    req_pin_n[0] = 1'b0;
    tick(2);
    rd_check("R1 not yet", 1'b0, 8'h00);
    tick(1);
    rd_check("R1 R2 level set", 1'b0, 8'h02);
    check("R6 disabled", {15'd0, irq_valid}, 16'd0);
    wr_reg(1'b1, 8'h81);
    check("R5 vec0", irq_valid ? irq_vector : NONE, 16'h0003);
    do_ack(16'h0003);
    rd_check("R2 re-set after ack", 1'b0, 8'h02);
    req_pin_n[0] = 1'b1;
    tick(3);
    do_ack(16'h0003);
    rd_check("R4 cleared", 1'b0, 8'h00);
    check("R4 valid low", {15'd0, irq_valid}, 16'd0);

    // edge mode on source 1
    wr_reg(1'b0, 8'h04);
    wr_reg(1'b1, 8'h84);
    req_pin_n[1] = 1'b0;
    tick(3);
    check("R3 R5 vec1", irq_valid ? irq_vector : NONE, 16'h0013);
    do_ack(16'h0013);
    tick(3);
    check("R3 held low no retrigger", {15'd0, irq_valid}, 16'd0);
    req_pin_n[1] = 1'b1;
    tick(3);
    req_pin_n[1] = 1'b0;
    tick(3);
    check("R3 second edge", irq_valid ? irq_vector : NONE, 16'h0013);
    wr_reg(1'b0, 8'h04);
    check("R8 write 0 clears", {15'd0, irq_valid}, 16'd0);
    rd_check("R8 trig kept", 1'b0, 8'h04);
    req_pin_n[1] = 1'b1;
    tick(3);

    // priority with software-raised flags, level mode, pins idle
    wr_reg(1'b0, 8'h0A);
    rd_check("R8 write 1 sets", 1'b0, 8'h0A);
    wr_reg(1'b1, 8'h85);
    check("R7 src0 first", irq_valid ? irq_vector : NONE, 16'h0003);
    do_ack(16'h0003);
    do_ack(16'h0013);
    do_ack(NONE);
    check("R4 both served", {15'd0, irq_valid}, 16'd0);

    // gating and masked ack
    wr_reg(1'b0, 8'h0A);
    wr_reg(1'b1, 8'h05);
    check("R6 master off", {15'd0, irq_valid}, 16'd0);
    do_ack(NONE);
    wr_reg(1'b1, 8'h85);
    check("R10 flags kept", irq_valid ? irq_vector : NONE, 16'h0003);
    wr_reg(1'b1, 8'h84);
    check("R6 src0 masked", irq_valid ? irq_vector : NONE, 16'h0013);
    rd_check("R5 ctrl layout", 1'b0, 8'h0A);
    rd_check("R6 enable layout", 1'b1, 8'h84);

    tick(2);
    check("R4 queue drained", 16'(exp_q.size()), 16'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule